// File: doc/BRIEF.md
# Buffered Byte Peripheral Port

This block connects a small processor-style register bus to one input device and one output device. The processor sees three registers, selected by two low address bits under a chip-select. The data register reads the buffered input byte and writes the buffered output byte. The status register reports buffer state. The command register holds the interrupt enables. Each direction buffers one byte, so a busy processor or a busy device loses nothing.

Both device sides are valid/ready byte streams. On the input side, the block raises `in_ready` only while its input slot is empty. A device that offers a byte while the slot is full waits, holding `in_valid` and `in_data`. No byte is overwritten. On the output side, the block holds `out_valid` and `out_data` stable until the device takes the byte with `out_ready`. The processor learns about new input, or about a completed output, either by polling the status register or through a held interrupt request. That request stays high until the processor pulses the acknowledge pin.

Top module: `ppi_port`

## Requirements
- R1: After reset, `irq` is 0, `in_ready` is 1, `out_valid` is 0, and the status register reads 8'h02.
- R2: While `cs` is 0, strobes on `rd` and `wr` change no state, and `rdata` is 0.
- R3: Address decode is: 2'b00 is the data register, 2'b01 is status (read-only, writes ignored), 2'b10 is command (write-only, reads return 0), and 2'b11 reads 0 and ignores writes.
- R4: `in_ready` is 1 only while the input slot is empty. An accepted byte is held, and a data-register read returns it and empties the slot.
- R5: A data-register write into an empty output slot loads it. `out_valid` is then held with stable `out_data` until `out_ready`. A write while the slot is full and not being taken is dropped.
- R6: A data-register write in the same cycle that the device takes the current output byte is accepted as the next output byte.
- R7: Status bit 0 is input-available, bit 1 is output-done (no output byte pending), bit 2 is interrupt pending, and bits 7:3 read 0.
- R8: With command bit 0 set, accepting an input byte sets `irq` at the same clock edge. With command bit 1 set, the device taking an output byte sets `irq`.
- R9: Once set, `irq` stays 1 until a cycle with `inta` high. Reading the data register does not clear it.
- R10: When `inta` coincides with a new enabled interrupt event, `irq` stays 1.
- R11: With both command bits clear (polled mode), no transfer sets `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register select |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| in_valid | input | 1 | Input device offers a byte |
| in_ready | output | 1 | Input slot empty |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte pending |
| out_ready | input | 1 | Output device takes the byte |
| out_data | output | 8 | Output byte |
| irq | output | 1 | Held interrupt request |
| inta | input | 1 | Interrupt acknowledge |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the acknowledge and a fresh enabled event. The bench pulses `inta` with an interrupt already pending in the same cycle that a new input byte is accepted. It then expects `irq` still high, and expects a later lone acknowledge to drop it. The second pair is a processor write and the device taking the byte. The bench raises `out_ready` in the very cycle of a data-register write into a full slot. It judges the outcome from `out_data`, which must carry the new byte after the edge, while `out_valid` stays high.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    ADR_DATA = 2'b00,
    ADR_STAT = 2'b01,
    ADR_CMD  = 2'b10,
    ADR_NONE = 2'b11
  } ppi_adr_e;

  typedef struct packed {
    logic out_irq_en;
    logic in_irq_en;
  } ppi_cmd_t;

  localparam int STAT_IN_AVAIL = 0;
  localparam int STAT_OUT_DONE = 1;
  localparam int STAT_IRQ      = 2;
endpackage

// File: rtl/ppi_in_slot.sv
module ppi_in_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] data,
  output logic         pushed
);
  assign push_ready = !full;
  assign pushed     = push_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (pushed) begin
      full <= 1'b1;
      data <= push_data;
    end else if (pop && full) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/ppi_out_slot.sv
module ppi_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take_ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         taken
);
  logic accept;
  assign taken  = valid && take_ready;
  assign accept = load && (!valid || taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (accept) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (taken) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ppi_irq_ctl.sv
module ppi_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_evt,
  input  logic out_evt,
  input  logic in_en,
  input  logic out_en,
  input  logic ack,
  output logic pend
);
  logic raise;
  assign raise = (in_evt && in_en) || (out_evt && out_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= 1'b0;
    else if (raise) pend <= 1'b1;
    else if (ack)   pend <= 1'b0;
  end
endmodule

// File: rtl/ppi_port.sv
module ppi_port
  import ppi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [1:0]        addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              irq,
  input  logic              inta
);
  localparam int CMD_W = $bits(ppi_cmd_t);

  ppi_adr_e          adr;
  logic              rd_data, wr_data, wr_cmd;
  logic              in_full, in_push, out_taken;
  logic [DATA_W-1:0] in_q;
  ppi_cmd_t          cmd_q;
  logic [DATA_W-1:0] stat;

  assign adr     = ppi_adr_e'(addr);
  assign rd_data = cs && rd && (adr == ADR_DATA);
  assign wr_data = cs && wr && (adr == ADR_DATA);
  assign wr_cmd  = cs && wr && (adr == ADR_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (wr_cmd) cmd_q <= ppi_cmd_t'(wdata[CMD_W-1:0]);
  end

  ppi_in_slot #(.W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_data(in_data), .push_ready(in_ready),
    .pop(rd_data), .full(in_full), .data(in_q), .pushed(in_push)
  );

  ppi_out_slot #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(wr_data), .load_data(wdata), .take_ready(out_ready),
    .valid(out_valid), .data(out_data), .taken(out_taken)
  );

  ppi_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n),
    .in_evt(in_push), .out_evt(out_taken),
    .in_en(cmd_q.in_irq_en), .out_en(cmd_q.out_irq_en),
    .ack(inta), .pend(irq)
  );

  always_comb begin
    stat                = '0;
    stat[STAT_IN_AVAIL] = in_full;
    stat[STAT_OUT_DONE] = !out_valid;
    stat[STAT_IRQ]      = irq;
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      case (adr)
        ADR_DATA: rdata = in_q;
        ADR_STAT: rdata = stat;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_port_chk.sv
module ppi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic [1:0]        addr,
  input logic              rd,
  input logic              wr,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              irq,
  input logic              inta,
  input logic [1:0]        cmd_bits
);
  logic pop_now;
  assign pop_now = cs && rd && (addr == 2'b00);

  a_r4_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !pop_now) |=> !in_ready);

  a_r5_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !inta) |=> irq);

  a_r8_in_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bits[0] && in_valid && in_ready) |=> irq);

  a_r8_out_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bits[1] && out_valid && out_ready) |=> irq);

  a_r11_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bits == 2'b00 && !irq) |=> !irq);

  a_r2_no_cs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(cmd_bits));
endmodule

bind ppi_port ppi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .irq(irq), .inta(inta),
  .cmd_bits(cmd_q)
);

// File: tb/tb_ppi_port.sv
module tb_ppi_port;
  logic       clk = 0, rst_n = 0;
  logic       cs = 0, rd = 0, wr = 0, in_valid = 0, out_ready = 0, inta = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, in_data = 0;
  logic [7:0] rdata, out_data;
  logic       in_ready, out_valid, irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ppi_port dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = c; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic c, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = c; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic dev_push(input logic [7:0] d);
    @(negedge clk); in_valid = 1; in_data = d;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic dev_take(output logic [7:0] d);
    @(negedge clk); out_ready = 1; d = out_data;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic ack();
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", irq, 0); chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    bus_rd(1, 2'b01, v); chk("R1 status", v, 8'h02);
  endtask

  task automatic t_cs_gate();
    logic [7:0] v;
    bus_wr(0, 2'b00, 8'h55); chk("R2 no load", out_valid, 0);
    bus_wr(0, 2'b10, 8'h01);
    dev_push(8'h3C);
    chk("R2 cmd unchanged", irq, 0);
    @(negedge clk); cs = 0; rd = 1; addr = 0; #1 chk("R2 rdata zero", rdata, 0);
    @(negedge clk); rd = 0;
    bus_rd(1, 2'b01, v); chk("R2 input kept", v[0], 1);
    bus_rd(1, 2'b00, v); chk("R4 read value", v, 8'h3C);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    bus_wr(1, 2'b01, 8'hFF); bus_wr(1, 2'b11, 8'hFF);
    bus_rd(1, 2'b01, v); chk("R3 status ro", v, 8'h02);
    chk("R3 no out", out_valid, 0);
    bus_wr(1, 2'b10, 8'h00);
    bus_rd(1, 2'b10, v); chk("R3 cmd reads zero", v, 0);
    bus_rd(1, 2'b11, v); chk("R3 none reads zero", v, 0);
  endtask

  task automatic t_input();
    logic [7:0] v;
    dev_push(8'hA1);
    chk("R4 not ready full", in_ready, 0);
    @(negedge clk); in_valid = 1; in_data = 8'hB2;
    @(negedge clk); chk("R4 back-pressure", in_ready, 0);
    bus_rd(1, 2'b01, v); chk("R7 in avail", v, 8'h03);
    bus_rd(1, 2'b00, v); chk("R4 held byte", v, 8'hA1);
    @(negedge clk); chk("R4 waiting byte taken", in_ready, 0); in_valid = 0;
    bus_rd(1, 2'b00, v); chk("R4 second byte", v, 8'hB2);
    chk("R4 empty again", in_ready, 1);
    chk("R11 polled no irq", irq, 0);
  endtask

  task automatic t_output();
    logic [7:0] v;
    bus_wr(1, 2'b00, 8'h11);
    chk("R5 valid", out_valid, 1);
    bus_rd(1, 2'b01, v); chk("R7 out pending", v, 8'h00);
    bus_wr(1, 2'b00, 8'h22);
    repeat (2) @(negedge clk);
    chk("R5 dropped write", out_data, 8'h11);
    @(negedge clk); out_ready = 1; cs = 1; wr = 1; addr = 0; wdata = 8'h33;
    @(negedge clk); out_ready = 0; cs = 0; wr = 0;
    chk("R6 valid kept", out_valid, 1); chk("R6 new byte", out_data, 8'h33);
    dev_take(v); chk("R5 taken byte", v, 8'h33);
    chk("R5 slot empty", out_valid, 0);
    chk("R11 polled no irq out", irq, 0);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bus_wr(1, 2'b10, 8'h01);
    dev_push(8'h44); chk("R8 in irq", irq, 1);
    bus_rd(1, 2'b00, v); chk("R9 held after read", irq, 1);
    bus_rd(1, 2'b01, v); chk("R7 irq bit", v, 8'h06);
    @(negedge clk); inta = 1; in_valid = 1; in_data = 8'h55;
    @(negedge clk); inta = 0; in_valid = 0;
    chk("R10 ack vs event", irq, 1);
    ack(); chk("R9 ack clears", irq, 0);
    bus_rd(1, 2'b00, v);
    bus_wr(1, 2'b10, 8'h02);
    bus_wr(1, 2'b00, 8'h66); chk("R8 not yet", irq, 0);
    dev_take(v); chk("R8 out irq", irq, 1);
    ack(); chk("R9 ack out", irq, 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset(); t_cs_gate(); t_decode(); t_input(); t_output(); t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule